// File: doc/BRIEF.md
# Wishbone Burst Slave Controller

This block sits on the slave side of a Wishbone bus and handles burst transfers into and out of a simple memory port further down. The master opens a burst by raising the cycle signal while the controller is idle. In that same clock edge the controller captures a start address, a beat count and the transfer direction. After that, each strobed beat is acknowledged one clock after it is taken. A write beat is forwarded to the downstream write port. A read beat is served from the downstream read port, which answers one clock after it is asked. The address advances by one for each beat taken.

The controller counts the beats that are left. It flags the beat that uses up the length, and after that beat it ignores every strobe until the master drops the cycle signal. If the master drops the cycle signal part way through a burst, the burst is abandoned and the controller goes back to idle. A beat is taken only when the strobe is high and no acknowledge is pending. So a master that holds its strobe and data steady until it sees the acknowledge gets exactly one transfer for that beat.

Top module: `wbBurstSlave`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ackOut`, `lastOut` and `wrEnOut` are low.
- R2: When `cycIn` is high while the controller is idle, `adrIn`, `lenIn` and `weIn` are captured at that edge, and the first beat of the burst uses `adrIn` as its address. No acknowledge is given in that opening cycle.
- R3: A beat is taken in a cycle where the burst is active, `cycIn` and `stbIn` are high and `ackOut` is low. `ackOut` is high for exactly the one cycle that follows. A strobe during the acknowledge cycle is not taken.
- R4: A write beat (`weIn` was 1 at the opening) drives `wrEnOut` high in its acknowledge cycle. In that cycle `wrAdrOut` is the beat address and `wrDatOut` is the `datIn` value seen when the beat was taken.
- R5: A cycle with `stbIn` low produces no acknowledge and no write, and it does not advance the address.
- R6: The address of beat k (counting from 0) is the start address plus k, modulo 2^ADDR_W.
- R7: A read beat (`weIn` was 0 at the opening) drives `rdEnOut` high, with `rdAdrOut` equal to the beat address, in the cycle it is taken. In the acknowledge cycle `datOut` equals `rdDatIn`, which the downstream port supplies one cycle after `rdEnOut`. Outside read acknowledge cycles `datOut` is zero.
- R8: `lastOut` is high together with `ackOut` on the beat that uses up the length, and low on every other beat. After that beat, strobes get no acknowledge and cause no write until `cycIn` goes low.
- R9: A `lenIn` of 0 gives a burst of exactly one beat.
- R10: `cycIn` going low before the final beat abandons the burst. No acknowledge follows any cycle in which `cycIn` was low, and the next rise of `cycIn` opens a new burst with fresh address and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Reset, active low, synchronous |
| cycIn | input | 1 | Bus cycle active |
| stbIn | input | 1 | Beat strobe |
| weIn | input | 1 | Direction captured at burst opening: 1 write, 0 read |
| adrIn | input | ADDR_W | Burst start address, captured at opening |
| lenIn | input | LEN_W | Burst length in beats, captured at opening; 0 means 1 |
| datIn | input | DATA_W | Write data for the current beat |
| ackOut | output | 1 | Beat acknowledge |
| lastOut | output | 1 | Marks the acknowledge of the final beat |
| datOut | output | DATA_W | Read data, valid while a read beat is acknowledged |
| wrEnOut | output | 1 | Downstream write enable |
| wrAdrOut | output | ADDR_W | Downstream write address |
| wrDatOut | output | DATA_W | Downstream write data |
| rdEnOut | output | 1 | Downstream read request |
| rdAdrOut | output | ADDR_W | Downstream read address |
| rdDatIn | input | DATA_W | Downstream read data, one cycle after the request |

## Verification
The assertions assume that `stbIn` is high only while `cycIn` is high. They also assume that the downstream read port returns data in exactly the cycle after `rdEnOut`, and that nothing else drives that port. The stimulus changes inputs only on falling clock edges. It raises the strobe only within a cycle, and the bench's own memory model answers every read request one clock later with a value computed from the address. Strobes while the cycle signal is low are used only to probe R10. In that case the properties still require no acknowledge.

// File: rtl/wbBurstPkg.sv
package wbBurstPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DRAIN  = 2'd2
  } burstState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic openBurst;   // capture address, length and direction
    logic takeBeat;    // a beat is accepted this cycle
  } ctrlStrobes_t;

  // Effective length: a zero count still moves one beat
  function automatic logic [31:0] effLen(input logic [31:0] raw);
    return (raw == 32'd0) ? 32'd1 : raw;
  endfunction

endpackage

// File: rtl/wbBurstCtrl.sv
module wbBurstCtrl
  import wbBurstPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cycIn,
  input  logic         stbIn,
  input  logic         finalBeat,
  output ctrlStrobes_t strobes,
  output logic         ackQ,
  output logic         lastQ,
  output logic         active
);

  burstState_t stateQ, stateD;

  logic beatOk;

  // A beat is taken only if no acknowledge is outstanding
  assign beatOk = (stateQ == ST_ACTIVE) && cycIn && stbIn && !ackQ;

  always_comb begin
    strobes.openBurst = (stateQ == ST_IDLE) && cycIn;
    strobes.takeBeat  = beatOk;
  end

  assign active = (stateQ == ST_ACTIVE);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (cycIn) stateD = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (!cycIn)                     stateD = ST_IDLE;
        else if (beatOk && finalBeat)   stateD = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!cycIn) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      ackQ   <= 1'b0;
      lastQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      ackQ   <= beatOk;
      lastQ  <= beatOk && finalBeat;
    end
  end

endmodule

// File: rtl/wbBurstData.sv
module wbBurstData
  import wbBurstPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] adrIn,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic              weIn,
  input  logic [DATA_W-1:0] datIn,
  output logic [ADDR_W-1:0] beatAdr,
  output logic              writeMode,
  output logic              finalBeat,
  output logic              wrEnQ,
  output logic [ADDR_W-1:0] wrAdrQ,
  output logic [DATA_W-1:0] wrDatQ
);

  localparam int REM_W = LEN_W + 1;
  localparam logic [REM_W-1:0] REM_ONE = REM_W'(1);

  logic [ADDR_W-1:0] adrQ;
  logic [REM_W-1:0]  remQ;
  logic              weQ;
  logic [REM_W-1:0]  openLen;

  assign openLen = REM_W'(effLen(32'(lenIn)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adrQ <= '0;
      remQ <= '0;
      weQ  <= 1'b0;
    end else if (strobes.openBurst) begin
      adrQ <= adrIn;
      remQ <= openLen;
      weQ  <= weIn;
    end else if (strobes.takeBeat) begin
      adrQ <= adrQ + ADDR_W'(1);
      remQ <= remQ - REM_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEnQ  <= 1'b0;
      wrAdrQ <= '0;
      wrDatQ <= '0;
    end else begin
      wrEnQ <= strobes.takeBeat && weQ;
      if (strobes.takeBeat && weQ) begin
        wrAdrQ <= adrQ;
        wrDatQ <= datIn;
      end
    end
  end

  assign beatAdr   = adrQ;
  assign writeMode = weQ;
  assign finalBeat = (remQ == REM_ONE);

endmodule

// File: rtl/wbBurstSlave.sv
module wbBurstSlave
  import wbBurstPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycIn,
  input  logic              stbIn,
  input  logic              weIn,
  input  logic [ADDR_W-1:0] adrIn,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic [DATA_W-1:0] datIn,
  output logic              ackOut,
  output logic              lastOut,
  output logic [DATA_W-1:0] datOut,
  output logic              wrEnOut,
  output logic [ADDR_W-1:0] wrAdrOut,
  output logic [DATA_W-1:0] wrDatOut,
  output logic              rdEnOut,
  output logic [ADDR_W-1:0] rdAdrOut,
  input  logic [DATA_W-1:0] rdDatIn
);

  ctrlStrobes_t      strobes;
  logic              finalBeat;
  logic              writeMode;
  logic              active;
  logic [ADDR_W-1:0] beatAdr;

  wbBurstCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cycIn     (cycIn),
    .stbIn     (stbIn),
    .finalBeat (finalBeat),
    .strobes   (strobes),
    .ackQ      (ackOut),
    .lastQ     (lastOut),
    .active    (active)
  );

  wbBurstData #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .adrIn     (adrIn),
    .lenIn     (lenIn),
    .weIn      (weIn),
    .datIn     (datIn),
    .beatAdr   (beatAdr),
    .writeMode (writeMode),
    .finalBeat (finalBeat),
    .wrEnQ     (wrEnOut),
    .wrAdrQ    (wrAdrOut),
    .wrDatQ    (wrDatOut)
  );

  // Read request goes out in the accepting cycle; the answer lands with ack
  assign rdEnOut  = strobes.takeBeat && !writeMode && active;
  assign rdAdrOut = beatAdr;
  assign datOut   = (ackOut && !writeMode) ? rdDatIn : '0;

endmodule

// File: rtl/wbBurstSlaveChk.sv
module wbBurstSlaveChk (
  input logic clk,
  input logic rstN,
  input logic cycIn,
  input logic stbIn,
  input logic ackOut,
  input logic lastOut,
  input logic wrEnOut,
  input logic rdEnOut
);

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |=> !ackOut); // R3

  AST_ACK_NEEDS_STB: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> $past(stbIn && cycIn)); // R3

  AST_WR_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    wrEnOut |-> ackOut); // R4

  AST_RD_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    rdEnOut |-> (!ackOut && stbIn && cycIn)); // R7

  AST_RD_THEN_ACK: assert property (@(posedge clk) disable iff (!rstN)
    rdEnOut |=> (ackOut && !wrEnOut)); // R7

  AST_LAST_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    lastOut |-> ackOut); // R8

  AST_NO_ACK_IDLE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !cycIn |=> !ackOut); // R10

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEnOut && rdEnOut)); // R4

endmodule

bind wbBurstSlave wbBurstSlaveChk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cycIn   (cycIn),
  .stbIn   (stbIn),
  .ackOut  (ackOut),
  .lastOut (lastOut),
  .wrEnOut (wrEnOut),
  .rdEnOut (rdEnOut)
);

// File: tb/wbBurstSlave_bench.sv
module wbBurstSlave_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 5;

  logic              clk = 1'b0;
  logic              rstN;
  logic              cycIn, stbIn, weIn;
  logic [ADDR_W-1:0] adrIn;
  logic [LEN_W-1:0]  lenIn;
  logic [DATA_W-1:0] datIn;
  logic              ackOut, lastOut, wrEnOut, rdEnOut;
  logic [DATA_W-1:0] datOut, wrDatOut;
  logic [ADDR_W-1:0] wrAdrOut, rdAdrOut;
  logic [DATA_W-1:0] rdDatIn;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbBurstSlave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_wbBurstSlave (
    .clk(clk), .rstN(rstN), .cycIn(cycIn), .stbIn(stbIn), .weIn(weIn),
    .adrIn(adrIn), .lenIn(lenIn), .datIn(datIn), .ackOut(ackOut),
    .lastOut(lastOut), .datOut(datOut), .wrEnOut(wrEnOut),
    .wrAdrOut(wrAdrOut), .wrDatOut(wrDatOut), .rdEnOut(rdEnOut),
    .rdAdrOut(rdAdrOut), .rdDatIn(rdDatIn)
  );

  function automatic logic [DATA_W-1:0] memVal(input logic [ADDR_W-1:0] a);
    return DATA_W'(16'h5A00 ^ (32'(a) * 32'h0107));
  endfunction

  // Downstream memory model: one cycle read latency
  always @(posedge clk) begin
    if (rdEnOut) rdDatIn <= memVal(rdAdrOut);
    else         rdDatIn <= 16'hDEAD;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic openBurst(input logic we, input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] n);
    @(negedge clk);
    cycIn = 1'b1; stbIn = 1'b0; weIn = we; adrIn = a; lenIn = n;
    @(negedge clk);
    chk("R2 no ack in opening cycle", 32'(ackOut), 32'd0);
    adrIn = '1; lenIn = '1; weIn = ~we; // later changes must not matter
  endtask

  task automatic doBeat(input logic we, input logic [DATA_W-1:0] d,
                        input logic [ADDR_W-1:0] expAdr, input logic expLast);
    @(negedge clk);
    stbIn = 1'b1; datIn = d;
    #1;
    if (!we) begin
      chk("R7 read request", 32'(rdEnOut), 32'd1);
      chk("R7 R6 read address", 32'(rdAdrOut), 32'(expAdr));
    end
    @(negedge clk);
    chk("R3 ack one cycle after strobe", 32'(ackOut), 32'd1);
    chk("R8 last flag", 32'(lastOut), 32'(expLast));
    if (we) begin
      chk("R4 write enable", 32'(wrEnOut), 32'd1);
      chk("R4 R6 write address", 32'(wrAdrOut), 32'(expAdr));
      chk("R4 write data", 32'(wrDatOut), 32'(d));
    end else begin
      chk("R7 read data", 32'(datOut), 32'(memVal(expAdr)));
      chk("R7 no write on read", 32'(wrEnOut), 32'd0);
    end
    stbIn = 1'b0; datIn = 16'hBAD0;
    @(negedge clk);
    chk("R3 ack lasts one cycle", 32'(ackOut), 32'd0);
    chk("R7 datOut zero outside ack", 32'(datOut), 32'd0);
  endtask

  task automatic probeIgnored(input string req, input logic stb);
    @(negedge clk);
    stbIn = stb; datIn = 16'hEEEE;
    @(negedge clk);
    chk(req, 32'({ackOut, wrEnOut, lastOut}), 32'd0);
    stbIn = 1'b0;
  endtask

  task automatic closeCycle();
    @(negedge clk);
    cycIn = 1'b0; stbIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0; cycIn = 1'b0; stbIn = 1'b0; weIn = 1'b0;
    adrIn = '0; lenIn = '0; datIn = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset ack/last/wr", 32'({ackOut, lastOut, wrEnOut}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 32'({ackOut, lastOut, wrEnOut}), 32'd0);
  endtask

  task automatic testWriteBurst();
    openBurst(1'b1, 8'h10, 5'd4);
    for (int i = 0; i < 4; i++)
      doBeat(1'b1, DATA_W'(16'h1000 + i), ADDR_W'(8'h10 + i), i == 3);
    probeIgnored("R8 strobe after final beat ignored", 1'b1);
    closeCycle();
  endtask

  task automatic testGaps();
    openBurst(1'b1, 8'h30, 5'd3);
    doBeat(1'b1, 16'hA1A1, 8'h30, 1'b0);
    probeIgnored("R5 no strobe, no ack or write", 1'b0);
    probeIgnored("R5 no strobe, second gap", 1'b0);
    doBeat(1'b1, 16'hA2A2, 8'h31, 1'b0);
    doBeat(1'b1, 16'hA3A3, 8'h32, 1'b1);
    closeCycle();
  endtask

  task automatic testHeld();
    // strobe held across the ack cycle: the beat is taken once per handshake
    openBurst(1'b1, 8'h50, 5'd2);
    @(negedge clk);
    stbIn = 1'b1; datIn = 16'hC001;
    @(negedge clk);
    chk("R3 held beat acked", 32'(ackOut), 32'd1);
    chk("R4 held beat address", 32'(wrAdrOut), 32'h50);
    datIn = 16'hC002; // next beat presented during ack, taken only after it
    @(negedge clk);
    chk("R3 no ack right after ack", 32'(ackOut), 32'd0);
    @(negedge clk);
    chk("R3 second beat acked", 32'(ackOut), 32'd1);
    chk("R6 second held beat address", 32'(wrAdrOut), 32'h51);
    chk("R4 second held beat data", 32'(wrDatOut), 32'hC002);
    chk("R8 final held beat", 32'(lastOut), 32'd1);
    stbIn = 1'b0;
    closeCycle();
  endtask

  task automatic testReadBurst();
    openBurst(1'b0, 8'hFE, 5'd3);
    doBeat(1'b0, 16'h0, 8'hFE, 1'b0);
    doBeat(1'b0, 16'h0, 8'hFF, 1'b0);
    doBeat(1'b0, 16'h0, 8'h00, 1'b1); // R6 wraps
    closeCycle();
  endtask

  task automatic testZeroLen();
    openBurst(1'b1, 8'h77, 5'd0);
    doBeat(1'b1, 16'h7777, 8'h77, 1'b1); // R9
    probeIgnored("R9 zero length gives one beat", 1'b1);
    closeCycle();
  endtask

  task automatic testAbort();
    openBurst(1'b1, 8'h40, 5'd5);
    doBeat(1'b1, 16'h4040, 8'h40, 1'b0);
    doBeat(1'b1, 16'h4141, 8'h41, 1'b0);
    @(negedge clk);
    cycIn = 1'b0;
    probeIgnored("R10 strobe without cycle ignored", 1'b1);
    openBurst(1'b1, 8'h60, 5'd2);
    doBeat(1'b1, 16'h6060, 8'h60, 1'b0); // R10 fresh start address
    doBeat(1'b1, 16'h6161, 8'h61, 1'b1);
    closeCycle();
  endtask

  initial begin
    testReset();
    testWriteBurst();
    testGaps();
    testHeld();
    testReadBurst();
    testZeroLen();
    testAbort();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule